// File: doc/BRIEF.md
# Serial-Clocked Conversion Frame Sequencer

This block runs one analog-to-digital conversion frame with the serial clock as the conversion clock. While chip select is low it watches the serial data line. The first logic 1 clocked in on a rising serial-clock edge opens a frame. The few control bits that follow choose the output code format and one of two frame lengths. From that point the block counts falling serial-clock edges. From the count it drives a track/hold control, a conversion strobe and a one-hot successive-approximation step enable. It then shifts the 14-bit result out MSB first.

The comparator is not modelled. The converted value arrives on a parallel `result` input as offset binary and is latched at the end of acquisition. All serial-clock edges are detected against a faster system clock. Raising chip select part way through freezes the frame, and it resumes where it stopped once chip select falls again. While chip select is high, both serial outputs are released.

Top module: `conv_frame_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of a frame, `strobe`, `sample_hold`, `sar_step`, `dout` and `frame_done` are all 0.
- R2: While idle, serial-clock pulses with `din` at 0 have no effect. The first `din` = 1 sampled on a rising `sclk` edge with `cs_n` low is the start bit, and it is falling edge 1 of the frame.
- R3: Control bits follow the start bit in this order: format, an unused bit, mode high, mode low, then three unused bits. Any mode other than 11 gives a short frame. `strobe` is high exactly between falling edges 7 and 8. The MSB is on `dout` after falling edge 8 and the LSB after edge 21. The frame ends at edge 24.
- R4: Mode 11 gives a long frame. `strobe` is high exactly between falling edges 15 and 16. The MSB appears after edge 16 and the LSB after edge 29. The frame ends at edge 32.
- R5: `sample_hold` is high from falling edge 2 until the falling edge on which `strobe` rises, and is never high together with `strobe`.
- R6: After falling edge A+k, where A is 7 (short) or 15 (long) and k is 0 to 13, `sar_step` has only bit 13-k set. Otherwise it is 0.
- R7: `result` is sampled on falling edge A. With format bit 1 (unipolar), `dout` carries `result` unchanged. With format bit 0 (bipolar), it carries `result` with its MSB inverted (two's complement). Bits go out MSB first, and `dout` changes only on falling edges.
- R8: `dout` is 0 before the MSB and after the LSB, up to the end of the frame.
- R9: While `cs_n` is high, `dout_oe` and `strobe_oe` are 0 and `sclk` edges are ignored. Outputs and the frame position hold, and the frame continues from the same edge count after `cs_n` falls.
- R10: `frame_done` pulses for one system clock on the final falling edge. The block then returns to idle and accepts a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, also the conversion clock |
| din | input | 1 | Serial control input |
| result | input | 14 | Converted value, offset binary |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Drive enable for `dout` |
| strobe | output | 1 | Conversion strobe |
| strobe_oe | output | 1 | Drive enable for `strobe` |
| sample_hold | output | 1 | High while tracking the input |
| sar_step | output | 14 | One-hot bit-decision enable |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong edge count shows up within one serial-clock period as a `strobe` that is shifted away from edge 7 or 15. The same fault misplaces the `sar_step` one-hot and ends `sample_hold` early or late. A wrong mode or format latch appears only when the frame is read back: the word shifts by eight bit positions, its MSB is inverted, or `frame_done` lands on edge 24 instead of 32. A frame that does not freeze while chip select is high shows as changed outputs during the pause and as a word offset after the pause.

// File: rtl/conv_frame_seq.sv
module conv_frame_seq #(
  parameter int W             = 14,
  parameter int SHORT_ACQ_END = 7,
  parameter int LONG_ACQ_END  = 15,
  parameter int SHORT_FRAME   = 24,
  parameter int LONG_FRAME    = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         din,
  input  logic [W-1:0] result,
  output logic         dout,
  output logic         dout_oe,
  output logic         strobe,
  output logic         strobe_oe,
  output logic         sample_hold,
  output logic [W-1:0] sar_step,
  output logic         frame_done
);
  localparam int CW = $clog2(LONG_FRAME + W + 1);
  localparam logic [CW-1:0] WV = CW'(W);

  logic          sclk_q, active, uni, m_hi, m_lo;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;

  wire rise    = !cs_n && sclk && !sclk_q;
  wire fall    = !cs_n && !sclk && sclk_q;
  wire long_md = m_hi & m_lo;

  wire [CW-1:0] acq_end  = long_md ? CW'(LONG_ACQ_END) : CW'(SHORT_ACQ_END);
  wire [CW-1:0] fr_end   = long_md ? CW'(LONG_FRAME)   : CW'(SHORT_FRAME);
  wire [CW-1:0] acq_last = acq_end + WV;
  wire [CW-1:0] nxt      = cnt + 1'b1;
  wire [W-1:0]  coded    = uni ? result : {~result[W-1], result[W-2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      active     <= 1'b0;
      uni        <= 1'b0;
      m_hi       <= 1'b0;
      m_lo       <= 1'b0;
      cnt        <= '0;
      sh         <= '0;
      dout       <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      sclk_q     <= sclk;
      frame_done <= 1'b0;
      if (!active) begin
        if (rise && din) begin
          active <= 1'b1;
          cnt    <= '0;
          uni    <= 1'b0;
          m_hi   <= 1'b0;
          m_lo   <= 1'b0;
          dout   <= 1'b0;
        end
      end else begin
        if (rise) begin
          if (cnt == CW'(1)) uni  <= din;
          if (cnt == CW'(3)) m_hi <= din;
          if (cnt == CW'(4)) m_lo <= din;
        end
        if (fall) begin
          cnt <= nxt;
          if (nxt == acq_end) begin
            sh   <= coded;
            dout <= 1'b0;
          end else if (nxt > acq_end && nxt <= acq_last) begin
            dout <= sh[W-1];
            sh   <= {sh[W-2:0], 1'b0};
          end else begin
            dout <= 1'b0;
          end
          if (nxt == fr_end) begin
            active     <= 1'b0;
            frame_done <= 1'b1;
          end
        end
      end
    end
  end

  assign dout_oe     = !cs_n;
  assign strobe_oe   = !cs_n;
  assign strobe      = active && (cnt == acq_end);
  assign sample_hold = active && (cnt >= CW'(2)) && (cnt < acq_end);

  always_comb begin
    sar_step = '0;
    for (int i = 0; i < W; i++)
      if (active && cnt == acq_end + CW'(i)) sar_step[W-1-i] = 1'b1;
  end
endmodule

// File: rtl/conv_frame_seq_chk.sv
module conv_frame_seq_chk #(
  parameter int W = 14
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         dout_oe,
  input logic         strobe_oe,
  input logic         strobe,
  input logic         sample_hold,
  input logic [W-1:0] sar_step,
  input logic         frame_done
);
  p_step_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sar_step));

  p_hold_vs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_hold && strobe));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!dout_oe && !strobe_oe));

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n ##1 cs_n |-> ($stable(strobe) && $stable(sar_step) && $stable(sample_hold)));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_strobe_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> sar_step[W-1]);
endmodule

bind conv_frame_seq conv_frame_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout_oe(dout_oe),
  .strobe_oe(strobe_oe), .strobe(strobe), .sample_hold(sample_hold),
  .sar_step(sar_step), .frame_done(frame_done)
);

// File: tb/tb_conv_frame_seq.sv
module tb_conv_frame_seq;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [13:0] result = '0;
  logic dout, dout_oe, strobe, strobe_oe, sample_hold, frame_done;
  logic [13:0] sar_step;

  int total = 0, bad = 0, done_cnt = 0, done_at = 0, cur_n = 0;

  always #2 clk = ~clk;

  conv_frame_seq dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .result(result), .dout(dout), .dout_oe(dout_oe), .strobe(strobe),
    .strobe_oe(strobe_oe), .sample_hold(sample_hold), .sar_step(sar_step),
    .frame_done(frame_done)
  );

  always @(negedge clk) if (frame_done) begin done_cnt++; done_at = cur_n; end

  // {format, mode[1:0], result, expected word}
  localparam logic [30:0] VEC [8] = '{
    {1'b1, 2'b00, 14'h2A5C, 14'h2A5C},
    {1'b0, 2'b00, 14'h2A5C, 14'h0A5C},
    {1'b1, 2'b11, 14'h3FFF, 14'h3FFF},
    {1'b0, 2'b11, 14'h0000, 14'h2000},
    {1'b0, 2'b00, 14'h2000, 14'h0000},
    {1'b1, 2'b11, 14'h0001, 14'h0001},
    {1'b1, 2'b01, 14'h1555, 14'h1555},
    {1'b0, 2'b10, 14'h3FFF, 14'h1FFF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic d);
    @(negedge clk);
    din = d; sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pause_cs();
    logic s0, h0, d0;
    logic [13:0] st0;
    cs_n = 1'b1;
    @(negedge clk);
    chk(!dout_oe && !strobe_oe, "R9 release", {dout_oe, strobe_oe}, 0);
    s0 = strobe; h0 = sample_hold; d0 = dout; st0 = sar_step;
    pulse(1'b1); pulse(1'b1); pulse(1'b0);
    chk(strobe === s0 && sample_hold === h0 && dout === d0 && sar_step === st0,
        "R9 frozen", {strobe, sample_hold, dout, sar_step}, {s0, h0, d0, st0});
    cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(input logic fmt, input logic [1:0] m, input logic [13:0] res,
                           input logic [13:0] expw, input int lead0, input int pause_at,
                           input string wtag);
    int a, fr, e_str, e_hold, e_step, e_pad, d0;
    logic [13:0] word, exp_step;
    string ftag;
    logic d;
    a  = (m == 2'b11) ? 15 : 7;
    fr = (m == 2'b11) ? 32 : 24;
    ftag = (m == 2'b11) ? "R4" : "R3";
    e_str = 0; e_hold = 0; e_step = 0; e_pad = 0; word = '0; d0 = done_cnt;
    result = res;
    cs_n = 1'b0;
    for (int i = 0; i < lead0; i++) begin
      pulse(1'b0);
      if (strobe !== 1'b0 || sample_hold !== 1'b0 || sar_step !== '0) e_hold++;
    end
    if (lead0 > 0) chk(e_hold == 0, "R2 zeros ignored", e_hold, 0);
    e_hold = 0;
    for (int n = 1; n <= fr; n++) begin
      d = (n == 1) ? 1'b1 : (n == 2) ? fmt : (n == 4) ? m[1] : (n == 5) ? m[0] : 1'b0;
      cur_n = n;
      pulse(d);
      if (n == a) result = ~res;
      if (strobe !== (n == a)) e_str++;
      if (sample_hold !== (n >= 2 && n < a)) e_hold++;
      exp_step = (n >= a && n <= a + 13) ? (14'h2000 >> (n - a)) : 14'h0;
      if (sar_step !== exp_step) e_step++;
      if (n >= a + 1 && n <= a + 14) word[13 - (n - a - 1)] = dout;
      else if (dout !== 1'b0) e_pad++;
      if (n == pause_at) pause_cs();
    end
    chk(e_str == 0, ftag, e_str, 0);
    chk(e_hold == 0, "R5 hold window", e_hold, 0);
    chk(e_step == 0, "R6 step one-hot", e_step, 0);
    chk(word === expw, wtag, word, expw);
    chk(e_pad == 0, "R8 zero padding", e_pad, 0);
    chk(done_cnt == d0 + 1 && done_at == fr, "R10 done", done_at, fr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(strobe === 0 && sample_hold === 0 && sar_step === 0 && dout === 0 && frame_done === 0,
        "R1 reset state", {strobe, sample_hold, sar_step, dout}, 0);

    foreach (VEC[k])
      run_frame(VEC[k][30], VEC[k][29:28], VEC[k][27:14], VEC[k][13:0], 0, 0, "R7 word");

    run_frame(1'b1, 2'b00, 14'h0C3A, 14'h0C3A, 5, 0, "R2 start after zeros");
    run_frame(1'b1, 2'b11, 14'h1234, 14'h1234, 2, 10, "R9 resume long");
    run_frame(1'b0, 2'b00, 14'h0F0F, 14'h2F0F, 0, 7, "R9 resume at strobe");
    run_frame(1'b1, 2'b00, 14'h2222, 14'h2222, 0, 4, "R9 resume in control");

    cs_n = 1'b0;
    for (int n = 1; n <= 12; n++) pulse(n == 1 ? 1'b1 : 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(strobe === 0 && sample_hold === 0 && sar_step === 0 && dout === 0,
        "R1 mid-frame reset", {strobe, sample_hold, sar_step, dout}, 0);
    run_frame(1'b1, 2'b11, 14'h0ABC, 14'h0ABC, 0, 0, "R10 restart after reset");

    cs_n = 1'b1;
    @(negedge clk);
    chk(!dout_oe && !strobe_oe, "R9 idle release", {dout_oe, strobe_oe}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule